// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a synchronous request bus and an external asynchronous static RAM with a 16-bit data path, 17 address bits and separate active-low enables for the low and high byte. A host offers one word access at a time on a valid/ready handshake, with a write flag, an address, write data and a two-bit byte mask. The block turns each access into a timed series of phases on the active-low chip enable, output enable, write enable and byte enable strobes. It also drives a direction control for the data pads.

Each phase lasts a set number of clock cycles, given by a parameter. Each count is the nanosecond minimum of the memory divided by the clock period, rounded up. The defaults fit a 100 MHz clock. A read holds chip enable, output enable and the selected byte enables low for 7 cycles, then captures the data. A write first holds write enable low with the pads released, so that the memory's output drivers can turn off. It then drives the data for the setup window and raises write enable as the only terminating edge. Chip enable, the byte enables and the address stay steady for one more cycle after that edge.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is applied, and for two cycles after it is released, all strobes are high, the pad drive enable is low, req_ready is low and rsp_valid is low.
- R2: A read (req_we low) holds chip enable and output enable low and write enable high for RD_CYC cycles (default 7), with sram_addr equal to the request address throughout. rsp_valid then pulses for one cycle, in the first cycle after the strobes return high.
- R3: req_mask bit 0 selects data bits 7:0 and drives sram_be_n[0] low. Bit 1 selects bits 15:8 and drives sram_be_n[1] low. In rsp_rdata a lane that was not selected reads as zero.
- R4: A write (req_we high) holds chip enable low and output enable high for the whole access, with sram_be_n equal to the inverted mask and sram_addr equal to the request address.
- R5: After write enable falls, the pad drive enable stays low for TURN_CYC cycles (default 3) before it rises.
- R6: The pad drive enable is high, with sram_dq_out equal to the request data, for WR_SETUP_CYC cycles (default 3) just before write enable rises. It falls on the same edge on which write enable rises.
- R7: Write enable stays low for at least WE_PULSE_CYC cycles (default 5). With the defaults it stays low for 6 cycles.
- R8: After write enable rises, chip enable, the byte enables and the address stay unchanged for one cycle, and then all strobes return high.
- R9: Only one access is outstanding at a time. req_ready is low from acceptance until the strobes are back high, and a request offered during that time is ignored.
- R10: A request with an empty mask keeps both byte enables high, so the memory stays deselected. No byte is written, and a read returns zero.
- R11: Output enable and write enable are never low together. The pad drive enable is high only while chip enable and write enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken on this edge when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte lane select, bit 0 low byte |
| rsp_valid | output | 1 | One-cycle read completion pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| sram_addr | output | 17 | Memory address |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_be_n | output | 2 | Byte enables, bit 0 low byte, active low |
| sram_dq_out | output | 16 | Data toward the pads |
| sram_dq_oe | output | 1 | Pad drive enable |
| sram_dq_in | input | 16 | Data from the pads |

## Verification
Writes and reads run with a full mask, with each single lane and with an empty mask, at both the lowest and the highest address. Readback against a shadow model then shows whether lanes are kept apart and whether deselection protects the word. The bench's memory model returns garbage until the read strobes have been low for seven cycles, and it commits only data that was driven before write enable rose. A read that is too short or a write with no setup window therefore shows up as wrong data. Other tests issue a request while an access is in progress, and a read straight after a write, to check that the block refuses the extra request and leaves a deselected gap between accesses.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READ,
    PH_WLEAD,
    PH_WDATA,
    PH_WEND
  } phase_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } strobe_t;

  localparam strobe_t STROBE_OFF = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int LANES = 2,
  parameter int LW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                capture,
  input  logic [LANES-1:0]    lane_en,
  input  logic [LANES*LW-1:0] dq_in,
  output logic [LANES*LW-1:0] rdata
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] lane_q, lane_d;

    always_comb begin
      lane_d = lane_q;
      if (capture) lane_d = lane_en[g] ? dq_in[g*LW +: LW] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else        lane_q <= lane_d;
    end

    assign rdata[g*LW +: LW] = lane_q;
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int DATA_W       = 16,
  parameter int RD_CYC       = 7,
  parameter int WE_PULSE_CYC = 5,
  parameter int WR_SETUP_CYC = 3,
  parameter int TURN_CYC     = 3,
  localparam int LANES       = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [LANES-1:0]  sram_be_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam int PULSE_REST = (WE_PULSE_CYC > WR_SETUP_CYC) ? WE_PULSE_CYC - WR_SETUP_CYC : 1;
  localparam int WR_LEAD    = (TURN_CYC > PULSE_REST) ? TURN_CYC : PULSE_REST;
  localparam int MAX_A      = (RD_CYC > WR_LEAD) ? RD_CYC : WR_LEAD;
  localparam int MAX_CYC    = (MAX_A > WR_SETUP_CYC) ? MAX_A : WR_SETUP_CYC;
  localparam int CW         = $clog2(MAX_CYC + 1);

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  phase_e            st_q, st_d;
  strobe_t           str_q, str_d;
  logic [LANES-1:0]  be_n_q, be_n_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] dout_q;
  logic              rsp_q, rsp_d;
  logic              accept, t_load, t_exp, cap;
  logic [CW-1:0]     t_val;

  assign req_ready = rst_i_n && (st_q == PH_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    st_d   = st_q;
    str_d  = str_q;
    be_n_d = be_n_q;
    rsp_d  = 1'b0;
    t_load = 1'b0;
    t_val  = '0;
    cap    = 1'b0;
    unique case (st_q)
      PH_IDLE: begin
        if (accept) begin
          be_n_d     = ~req_mask;
          t_load     = 1'b1;
          str_d.ce_n = 1'b0;
          if (req_we) begin
            st_d       = PH_WLEAD;
            str_d.we_n = 1'b0;
            t_val      = CW'(WR_LEAD - 1);
          end else begin
            st_d       = PH_READ;
            str_d.oe_n = 1'b0;
            t_val      = CW'(RD_CYC - 1);
          end
        end
      end
      PH_READ: begin
        if (t_exp) begin
          cap    = 1'b1;
          rsp_d  = 1'b1;
          st_d   = PH_IDLE;
          str_d  = STROBE_OFF;
          be_n_d = '1;
        end
      end
      PH_WLEAD: begin
        if (t_exp) begin
          st_d        = PH_WDATA;
          str_d.dq_oe = 1'b1;
          t_load      = 1'b1;
          t_val       = CW'(WR_SETUP_CYC - 1);
        end
      end
      PH_WDATA: begin
        if (t_exp) begin
          st_d        = PH_WEND;
          str_d.we_n  = 1'b1;
          str_d.dq_oe = 1'b0;
        end
      end
      PH_WEND: begin
        st_d   = PH_IDLE;
        str_d  = STROBE_OFF;
        be_n_d = '1;
      end
      default: begin
        st_d   = PH_IDLE;
        str_d  = STROBE_OFF;
        be_n_d = '1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= PH_IDLE;
      str_q  <= STROBE_OFF;
      be_n_q <= '1;
      rsp_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      str_q  <= str_d;
      be_n_q <= be_n_d;
      rsp_q  <= rsp_d;
    end
  end

  // request payload, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      addr_q <= '0;
      dout_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      dout_q <= req_wdata;
    end
  end

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_exp)
  );

  sram_rd_capture #(.LANES(LANES), .LW(8)) u_cap (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .capture (cap),
    .lane_en (~be_n_q),
    .dq_in   (sram_dq_in),
    .rdata   (rsp_rdata)
  );

  assign rsp_valid   = rsp_q;
  assign sram_addr   = addr_q;
  assign sram_ce_n   = str_q.ce_n;
  assign sram_oe_n   = str_q.oe_n;
  assign sram_we_n   = str_q.we_n;
  assign sram_dq_oe  = str_q.dq_oe;
  assign sram_be_n   = be_n_q;
  assign sram_dq_out = dout_q;

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W       = 17,
  parameter int LANES        = 2,
  parameter int WE_PULSE_CYC = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic [LANES-1:0]  sram_be_n,
  input logic              sram_dq_oe
);

  logic [15:0] we_low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          we_low_q <= '0;
    else if (!sram_we_n) we_low_q <= we_low_q + 1'b1;
    else                 we_low_q <= '0;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && sram_oe_n && sram_we_n && (&sram_be_n) && !sram_dq_oe));

  // R11
  no_oe_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> sram_we_n);

  // R11
  drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (!sram_we_n && !sram_ce_n && sram_oe_n));

  // R5
  turn_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> !sram_dq_oe);

  // R6
  setup_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> ($past(sram_dq_oe) && !sram_dq_oe));

  // R8
  hold_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (!sram_ce_n && $stable(sram_addr) && $stable(sram_be_n)));

  // R2
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

  // R2
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(!sram_oe_n) && sram_oe_n));

  // R9
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n |-> !req_ready);

  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_low_q >= 16'(WE_PULSE_CYC)));

endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W       (ADDR_W),
  .LANES        (LANES),
  .WE_PULSE_CYC (WE_PULSE_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .sram_addr  (sram_addr),
  .sram_ce_n  (sram_ce_n),
  .sram_oe_n  (sram_oe_n),
  .sram_we_n  (sram_we_n),
  .sram_be_n  (sram_be_n),
  .sram_dq_oe (sram_dq_oe)
);

// File: tb/sim_sram_ctrl.sv
module sim_sram_ctrl;

  localparam int RD_CYC = 7;
  localparam int TURN   = 3;
  localparam int SETUP  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic        req_ready;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [16:0] sram_addr;
  logic        sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [1:0]  sram_be_n;
  logic [15:0] sram_dq_out, sram_dq_in;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  sram_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_be_n(sram_be_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  // behavioural memory: slow read, commits only data driven before the write ends
  logic [15:0] mem [0:255];
  logic [15:0] shadow [0:255];
  int          rd_cnt = 0;
  logic [15:0] pend_d;
  bit          pend_v = 1'b0;
  logic        rd_act;

  assign rd_act = !sram_ce_n && !sram_oe_n && sram_we_n;

  always @(negedge clk) begin
    if (rd_act) rd_cnt <= rd_cnt + 1;
    else        rd_cnt <= 0;
    if (sram_we_n && pend_v) begin
      if (!sram_ce_n && !sram_be_n[0]) mem[sram_addr[7:0]][7:0]  <= pend_d[7:0];
      if (!sram_ce_n && !sram_be_n[1]) mem[sram_addr[7:0]][15:8] <= pend_d[15:8];
      pend_v <= 1'b0;
    end else if (!sram_ce_n && !sram_we_n && sram_dq_oe) begin
      pend_d <= sram_dq_out;
      pend_v <= 1'b1;
    end
  end

  always_comb begin
    if (rd_act && rd_cnt >= RD_CYC) begin
      sram_dq_in[7:0]  = sram_be_n[0] ? 8'hA5 : mem[sram_addr[7:0]][7:0];
      sram_dq_in[15:8] = sram_be_n[1] ? 8'hA5 : mem[sram_addr[7:0]][15:8];
    end else begin
      sram_dq_in = 16'hDEAD;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic we, input logic [16:0] a, input logic [15:0] d, input logic [1:0] m);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [16:0] a, input logic [15:0] d, input logic [1:0] m);
    int ce_c = 0, we_c = 0, lead_c = 0, drv_c = 0;
    bit seen_drv = 0, bad_oe = 0, bad_be = 0, bad_addr = 0, bad_d = 0;
    issue(1'b1, a, d, m);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!sram_ce_n) begin
        ce_c++;
        if (sram_be_n != ~m) bad_be = 1;
        if (sram_addr != a)  bad_addr = 1;
      end
      if (!sram_oe_n) bad_oe = 1;
      if (!sram_we_n) begin
        we_c++;
        if (sram_dq_oe) begin
          drv_c++; seen_drv = 1;
          if (sram_dq_out != d) bad_d = 1;
        end else if (!seen_drv) lead_c++;
      end
      if (req_ready) break;
    end
    check(!bad_oe && !bad_be && !bad_addr, "R4 write strobes", {29'd0, bad_oe, bad_be, bad_addr}, 0);
    check(lead_c == TURN, "R5 turnaround", lead_c, TURN);
    check(drv_c == SETUP && !bad_d, "R6 data setup", drv_c, SETUP);
    check(we_c == TURN + SETUP, "R7 pulse width", we_c, TURN + SETUP);
    check(ce_c == we_c + 1 && sram_ce_n && (&sram_be_n), "R8 hold after end", ce_c, we_c + 1);
    if (m[0]) shadow[a[7:0]][7:0]  = d[7:0];
    if (m[1]) shadow[a[7:0]][15:8] = d[15:8];
  endtask

  task automatic do_read(input logic [16:0] a, input logic [1:0] m, input string req);
    int ce_c = 0;
    bit bad = 0, bad_be = 0, got = 0;
    logic [15:0] exp, act;
    exp = {m[1] ? shadow[a[7:0]][15:8] : 8'h00, m[0] ? shadow[a[7:0]][7:0] : 8'h00};
    act = '0;
    issue(1'b0, a, 16'h0, m);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!sram_ce_n) begin
        ce_c++;
        if (sram_oe_n || !sram_we_n || sram_dq_oe || sram_addr != a) bad = 1;
        if (sram_be_n != ~m) bad_be = 1;
      end
      if (rsp_valid) begin
        got = req_ready && sram_ce_n;
        act = rsp_rdata;
      end
      if (req_ready) break;
    end
    check(ce_c == RD_CYC && !bad, "R2 read strobes", ce_c, RD_CYC);
    check(!bad_be, "R3 byte enables", {30'd0, sram_be_n}, {30'd0, ~m});
    check(got, "R2 response timing", {31'd0, got}, 1);
    check(act == exp, req, act, exp);
  endtask

  task automatic test_reset;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(sram_ce_n && sram_oe_n && sram_we_n && (&sram_be_n) && !sram_dq_oe && !req_ready && !rsp_valid,
          "R1 reset state", {26'd0, sram_ce_n, sram_oe_n, sram_we_n, sram_be_n, sram_dq_oe}, 32'h3E);
    rst_n = 1'b1;
    @(negedge clk);
    check(!req_ready && sram_ce_n, "R1 release delay", {31'd0, req_ready}, 0);
    repeat (2) @(negedge clk);
    check(req_ready && sram_ce_n && !rsp_valid, "R1 ready after reset", {31'd0, req_ready}, 1);
  endtask

  task automatic test_full_words;
    do_write(17'h00010, 16'h1234, 2'b11);
    do_read(17'h00010, 2'b11, "R2 full word readback");
    do_write(17'h1FFFF, 16'hBEEF, 2'b11);
    do_read(17'h1FFFF, 2'b11, "R2 top address readback");
    do_write(17'h00000, 16'h0F0F, 2'b11);
    do_read(17'h00000, 2'b11, "R2 zero address readback");
  endtask

  task automatic test_lanes;
    do_write(17'h00010, 16'hABCD, 2'b01);
    do_read(17'h00010, 2'b11, "R3 low lane write");
    do_write(17'h00010, 16'h5600, 2'b10);
    do_read(17'h00010, 2'b11, "R3 high lane write");
    do_read(17'h00010, 2'b10, "R3 high lane read");
    do_read(17'h00010, 2'b01, "R3 low lane read");
  endtask

  task automatic test_empty_mask;
    do_write(17'h00010, 16'hFFFF, 2'b00);
    do_read(17'h00010, 2'b11, "R10 empty mask write");
    do_read(17'h1FFFF, 2'b00, "R10 empty mask read");
  endtask

  task automatic test_busy;
    bit bad = 0;
    issue(1'b1, 17'h00040, 16'h7777, 2'b11);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 17'h00041; req_mask = 2'b11;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (req_ready) break;
      if (sram_addr != 17'h00040 || rsp_valid) bad = 1;
    end
    req_valid = 1'b0;
    shadow[8'h40] = 16'h7777;
    check(!bad, "R9 request ignored while busy", {31'd0, bad}, 0);
    repeat (3) @(negedge clk);
    check(sram_ce_n && !rsp_valid, "R9 held request dropped", {31'd0, sram_ce_n}, 1);
    do_read(17'h00040, 2'b11, "R9 busy write landed");
  endtask

  task automatic test_back_to_back;
    bit gap = 0;
    do_write(17'h00022, 16'hC3C3, 2'b11);
    gap = sram_ce_n;
    do_read(17'h00022, 2'b11, "R8 read after write");
    check(gap, "R8 deselect gap", {31'd0, gap}, 1);
    check(!sram_dq_oe && sram_we_n, "R11 idle pads", {30'd0, sram_dq_oe, sram_we_n}, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = '0;
      shadow[i] = '0;
    end
    test_reset();
    test_full_words();
    test_lanes();
    test_empty_mask();
    test_busy();
    test_back_to_back();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++;
      fails++;
      $display("FAIL watchdog: actual %0d expected 0", 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule